// File: doc/BRIEF.md
# Configuration-Mode Unlock Gate

This block guards the configuration space of an I/O-port peripheral reached through an index/data port pair. In normal operation the configuration registers are hidden. Data-port reads return all ones and data-port writes are dropped. A host opens the space by writing a four-byte key to the index port. After that it selects a register by writing its number to the index port, and then reads or writes that register through the data port, which sits one address above the index port.

The peripheral can be placed at one of two base ports. A pin selects which one is live. The last key byte differs between the two placements. Configuration mode ends when a specific value is written to a specific indexed register, not by sending a second key.

Inside, there are read-only identity registers (a 16-bit device code and a revision byte), a device-select register that picks which bank of per-device registers the banked index range reaches, and a global control register whose bits are driven out to the rest of the chip.

Top module: `cfg_unlock_gate`

## Requirements
- R1: After reset the gate is locked (`cfg_active`=0), `cfg_ldn`=0x00, `cfg_ctrl`=0x00 and `io_rdata`=0xFF.
- R2: With `base_sel`=0 the index port is 0x2E. The writes 0x87, 0x01, 0x55, 0x55 to it raise `cfg_active` one cycle after the fourth write. Writes to other addresses between key bytes do not disturb the sequence.
- R3: With `base_sel`=1 the index port is 0x4E and the fourth key byte is 0xAA. Sending the other placement's fourth byte leaves the gate locked.
- R4: A wrong byte during the key returns the detector to its start. That byte is then re-tested as a first key byte, so 0x87, 0x87, 0x01, 0x55, <last> unlocks.
- R5: While locked, a read of the live index or data port returns 0xFF, and data-port writes change no register.
- R6: While unlocked, a write to the index port stores the register number, and a read of the index port returns it.
- R7: Register 0x20 reads the upper byte and 0x21 the lower byte of the device code. 0x22 reads the revision byte. Writes to these three are ignored.
- R8: Writing 0x02 to register 0x02 drops `cfg_active` on the next cycle. Any other value written there leaves the gate unlocked.
- R9: Register 0x07 holds the device select, also driven on `cfg_ldn`. Registers 0x30 to 0x33 have separate storage for each selected device. When the selected device is outside the implemented range, those registers read 0x00 and ignore writes.
- R10: Register 0x24 is global. It is not banked. Bits 5:0 are stored and driven on `cfg_ctrl` (bit 0 suspend, bits 3:1 flash segment enables, bit 4 host flash write enable, bit 5 flash pin select). Bits 7:6 read 0.
- R11: `io_rdata` is updated on the clock edge that samples `io_rd` to a live port. Otherwise it holds its value, including on reads of an address that is not live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_sel | input | 1 | 0: ports at 0x2E/0x2F, 1: ports at 0x4E/0x4F |
| io_wr | input | 1 | I/O write strobe, one cycle per byte |
| io_rd | input | 1 | I/O read strobe, one cycle per byte |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cfg_active | output | 1 | Configuration mode is open |
| cfg_ldn | output | 8 | Selected logical device |
| cfg_ctrl | output | 6 | Global control bits from register 0x24 |

## Verification
The key detector is tried with the correct key at each placement, with the other placement's last byte, with a repeated first byte that must restart the match, and with stray data-port writes between key bytes. Together these separate a detector that restarts at idle from one that re-tests the offending byte, and a detector that filters by address from one that counts every write.

Register access is tried with a locked read and a locked write, with writes to the identity registers, and with the same banked register written under two device selects and read back under the first. These show whether the lock gates the data path and whether the bank storage is really split per device. An exit write with a wrong value, followed by the correct one, tests the exact value match.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;

   typedef enum logic [1:0] {
      KEY_WAIT0,
      KEY_GOT1,
      KEY_GOT2,
      KEY_GOT3
   } key_st_e;

   localparam logic [7:0] KEY_B0 = 8'h87;
   localparam logic [7:0] KEY_B1 = 8'h01;
   localparam logic [7:0] KEY_B2 = 8'h55;

   localparam logic [7:0] IDX_EXIT  = 8'h02;
   localparam logic [7:0] IDX_LDN   = 8'h07;
   localparam logic [7:0] IDX_ID_HI = 8'h20;
   localparam logic [7:0] IDX_ID_LO = 8'h21;
   localparam logic [7:0] IDX_REV   = 8'h22;
   localparam logic [7:0] IDX_CTRL  = 8'h24;
   localparam logic [7:0] EXIT_VAL  = 8'h02;
   localparam logic [7:0] LOCKED_RD = 8'hFF;

   // expected key byte for a given progress state
   function automatic logic [7:0] key_expect(key_st_e st, logic [7:0] last_b);
      logic [7:0] r;
      case (st)
         KEY_WAIT0: r = KEY_B0;
         KEY_GOT1:  r = KEY_B1;
         KEY_GOT2:  r = KEY_B2;
         default:   r = last_b;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
   parameter int ADDR_W = 16,
   parameter int BASE_A = 'h2E,
   parameter int BASE_B = 'h4E
) (
   input  logic              base_sel,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [ADDR_W-1:0] io_addr,
   output logic              idx_wr,
   output logic              dat_wr,
   output logic              idx_rd,
   output logic              dat_rd
);

   localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(BASE_A);
   localparam logic [ADDR_W-1:0] IDX_B = ADDR_W'(BASE_B);
   localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(BASE_A + 1);
   localparam logic [ADDR_W-1:0] DAT_B = ADDR_W'(BASE_B + 1);

   logic idx_hit;
   logic dat_hit;

   always_comb begin
      idx_hit = base_sel ? (io_addr == IDX_B) : (io_addr == IDX_A);
      dat_hit = base_sel ? (io_addr == DAT_B) : (io_addr == DAT_A);
   end

   assign idx_wr = io_wr & idx_hit;
   assign dat_wr = io_wr & dat_hit;
   assign idx_rd = io_rd & idx_hit;
   assign dat_rd = io_rd & dat_hit;

endmodule

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
   import cfg_gate_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   input  logic [7:0] last_key,
   input  logic       exit_req,
   output logic       active
);

   key_st_e st_q, st_d;
   logic    active_q, active_d;

   always_comb begin
      st_d     = st_q;
      active_d = active_q;
      if (active_q) begin
         if (exit_req) begin
            active_d = 1'b0;
            st_d     = KEY_WAIT0;
         end
      end else if (idx_wr) begin
         if (wdata == key_expect(st_q, last_key)) begin
            case (st_q)
               KEY_WAIT0: st_d = KEY_GOT1;
               KEY_GOT1:  st_d = KEY_GOT2;
               KEY_GOT2:  st_d = KEY_GOT3;
               default: begin
                  st_d     = KEY_WAIT0;
                  active_d = 1'b1;
               end
            endcase
         end else begin
            // mismatch: restart, but the byte may open a new attempt
            st_d = (wdata == KEY_B0) ? KEY_GOT1 : KEY_WAIT0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= KEY_WAIT0;
         active_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         active_q <= active_d;
      end
   end

   assign active = active_q;

   AST_ENTRY_NEEDS_LAST_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_q) |-> ($past(idx_wr) && ($past(wdata) == $past(last_key)))); // R2
   AST_EXIT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && exit_req) |=> !active_q); // R8
   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !idx_wr) |=> !active_q); // R5
   AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !exit_req) |=> active_q); // R8

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
   import cfg_gate_pkg::*;
#(
   parameter int          NUM_LDN   = 8,
   parameter int          BANK_BASE = 'h30,
   parameter int          BANK_REGS = 4,
   parameter int          CTRL_W    = 6,
   parameter logic [15:0] CHIP_ID   = 16'h5A3C,
   parameter logic [7:0]  CHIP_REV  = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              idx_wr,
   input  logic              dat_wr,
   input  logic              idx_rd,
   input  logic              dat_rd,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic [7:0]        ldn,
   output logic [CTRL_W-1:0] ctrl,
   output logic              exit_req
);

   localparam int         LDN_W   = $clog2(NUM_LDN);
   localparam int         BANK_W  = $clog2(BANK_REGS);
   localparam logic [7:0] BANK_LO = 8'(BANK_BASE);
   localparam logic [7:0] BANK_HI = 8'(BANK_BASE + BANK_REGS - 1);
   localparam logic [7:0] LDN_LIM = 8'(NUM_LDN);

   logic [7:0]        idx_q;
   logic [7:0]        ldn_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [7:0]        rdata_q;

   logic              wr_ok;
   logic              bank_hit;
   logic              ldn_ok;
   logic [BANK_W-1:0] bank_sel;
   logic [LDN_W-1:0]  ldn_idx;
   logic [NUM_LDN-1:0][BANK_REGS-1:0][7:0] bank_rd;
   logic [7:0]        dat_val;

   assign wr_ok    = active & dat_wr;
   assign bank_hit = (idx_q >= BANK_LO) && (idx_q <= BANK_HI);
   assign ldn_ok   = ldn_q < LDN_LIM;
   assign bank_sel = BANK_W'(idx_q - BANK_LO);
   assign ldn_idx  = LDN_W'(ldn_q);
   assign exit_req = wr_ok && (idx_q == IDX_EXIT) && (wdata == EXIT_VAL);

   // index register: only reachable once the gate is open
   always_ff @(posedge clk) begin
      if (!rst_n)                idx_q <= 8'h00;
      else if (active && idx_wr) idx_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                            ldn_q <= 8'h00;
      else if (wr_ok && idx_q == IDX_LDN)    ldn_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                            ctrl_q <= '0;
      else if (wr_ok && idx_q == IDX_CTRL)   ctrl_q <= wdata[CTRL_W-1:0];
   end

   // one storage bank per logical device
   for (genvar g = 0; g < NUM_LDN; g++) begin : g_bank
      logic [BANK_REGS-1:0][7:0] regs_q;
      logic                      sel_me;

      assign sel_me = wr_ok && bank_hit && (ldn_q == 8'(g));

      always_ff @(posedge clk) begin
         if (!rst_n)      regs_q <= '0;
         else if (sel_me) regs_q[bank_sel] <= wdata;
      end

      assign bank_rd[g] = regs_q;
   end

   always_comb begin
      dat_val = 8'h00;
      if (bank_hit) begin
         if (ldn_ok) dat_val = bank_rd[ldn_idx][bank_sel];
      end else begin
         case (idx_q)
            IDX_LDN:   dat_val = ldn_q;
            IDX_ID_HI: dat_val = CHIP_ID[15:8];
            IDX_ID_LO: dat_val = CHIP_ID[7:0];
            IDX_REV:   dat_val = CHIP_REV;
            IDX_CTRL:  dat_val = 8'(ctrl_q);
            default:   dat_val = 8'h00;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            rdata_q <= LOCKED_RD;
      else if (!active && (idx_rd || dat_rd)) rdata_q <= LOCKED_RD;
      else if (idx_rd)       rdata_q <= idx_q;
      else if (dat_rd)       rdata_q <= dat_val;
   end

   assign rdata = rdata_q;
   assign ldn   = ldn_q;
   assign ctrl  = ctrl_q;

   AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
      ((idx_rd || dat_rd) && !active) |=> (rdata_q == LOCKED_RD)); // R5
   AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> $stable(ctrl_q)); // R10
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(idx_rd || dat_rd) |=> $stable(rdata_q)); // R11
   AST_LDN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(active && dat_wr) |=> $stable(ldn_q)); // R9

endmodule

// File: rtl/cfg_unlock_gate.sv
module cfg_unlock_gate
   import cfg_gate_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter int          BASE_A     = 'h2E,
   parameter int          BASE_B     = 'h4E,
   parameter logic [7:0]  KEY_LAST_A = 8'h55,
   parameter logic [7:0]  KEY_LAST_B = 8'hAA,
   parameter int          NUM_LDN    = 8,
   parameter int          BANK_BASE  = 'h30,
   parameter int          BANK_REGS  = 4,
   parameter logic [15:0] CHIP_ID    = 16'h5A3C,
   parameter logic [7:0]  CHIP_REV   = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_sel,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [15:0]       io_addr,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic              cfg_active,
   output logic [7:0]        cfg_ldn,
   output logic [5:0]        cfg_ctrl
);

   localparam int CTRL_W = 6;

   if (ADDR_W != 16) begin : g_chk_addr
      $error("ADDR_W must match the 16-bit io_addr port");
   end
   if (NUM_LDN < 2 || NUM_LDN > 256) begin : g_chk_ldn
      $error("NUM_LDN must lie in 2..256");
   end
   if (BANK_REGS < 2 || BANK_BASE + BANK_REGS > 256 || BANK_BASE <= 'h24) begin : g_chk_bank
      $error("banked range must sit above the global registers");
   end
   if (BASE_A == BASE_B) begin : g_chk_base
      $error("the two base ports must differ");
   end

   logic       idx_wr, dat_wr, idx_rd, dat_rd;
   logic       exit_req;
   logic       active;
   logic [7:0] last_key;

   assign last_key = base_sel ? KEY_LAST_B : KEY_LAST_A;

   cfg_port_decode #(
      .ADDR_W (ADDR_W),
      .BASE_A (BASE_A),
      .BASE_B (BASE_B)
   ) i_decode (
      .base_sel (base_sel),
      .io_wr    (io_wr),
      .io_rd    (io_rd),
      .io_addr  (io_addr),
      .idx_wr   (idx_wr),
      .dat_wr   (dat_wr),
      .idx_rd   (idx_rd),
      .dat_rd   (dat_rd)
   );

   cfg_key_fsm i_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_wr   (idx_wr),
      .wdata    (io_wdata),
      .last_key (last_key),
      .exit_req (exit_req),
      .active   (active)
   );

   cfg_regfile #(
      .NUM_LDN   (NUM_LDN),
      .BANK_BASE (BANK_BASE),
      .BANK_REGS (BANK_REGS),
      .CTRL_W    (CTRL_W),
      .CHIP_ID   (CHIP_ID),
      .CHIP_REV  (CHIP_REV)
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .idx_wr   (idx_wr),
      .dat_wr   (dat_wr),
      .idx_rd   (idx_rd),
      .dat_rd   (dat_rd),
      .wdata    (io_wdata),
      .rdata    (io_rdata),
      .ldn      (cfg_ldn),
      .ctrl     (cfg_ctrl),
      .exit_req (exit_req)
   );

   assign cfg_active = active;

   AST_RESET_LOCKED: assert property (@(posedge clk)
      !rst_n |=> !cfg_active); // R1

endmodule

// File: tb/test_cfg_unlock_gate.sv
module test_cfg_unlock_gate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_sel = 1'b0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [15:0] io_addr = 16'h0000;
   logic [7:0]  io_wdata = 8'h00;
   logic [7:0]  io_rdata;
   logic        cfg_active;
   logic [7:0]  cfg_ldn;
   logic [5:0]  cfg_ctrl;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       rd_seen = 1'b0;

   always #2 clk = ~clk;

   cfg_unlock_gate i_cfg_unlock_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .base_sel   (base_sel),
      .io_wr      (io_wr),
      .io_rd      (io_rd),
      .io_addr    (io_addr),
      .io_wdata   (io_wdata),
      .io_rdata   (io_rdata),
      .cfg_active (cfg_active),
      .cfg_ldn    (cfg_ldn),
      .cfg_ctrl   (cfg_ctrl)
   );

   // monitor: a read strobe sampled at an edge yields data by the next falling edge
   always @(posedge clk) rd_seen <= io_rd;

   always @(negedge clk) begin
      if (rd_seen) begin
         logic [7:0] e;
         string      t;
         n_checks++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R11 read with no expectation: actual %02h expected none", io_rdata);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (io_rdata !== e) begin
               n_fail++;
               $display("FAIL %s: actual %02h expected %02h", t, io_rdata, e);
            end
         end
      end
   end

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_wr = 1'b1; io_addr = a; io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      io_rd = 1'b1; io_addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic key(input logic [15:0] p, input logic [7:0] last);
      wr(p, 8'h87); wr(p, 8'h01); wr(p, 8'h55); wr(p, last);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(8'(cfg_active), 8'h00, "R1 active after reset");
      check(cfg_ldn, 8'h00, "R1 ldn after reset");
      check(8'(cfg_ctrl), 8'h00, "R1 ctrl after reset");
      check(io_rdata, 8'hFF, "R1 rdata after reset");

      // R5 locked access, base 0x2E
      wr(16'h002F, 8'h3F);
      rd(16'h002F, 8'hFF, "R5 locked data read");
      rd(16'h002E, 8'hFF, "R5 locked index read");
      check(8'(cfg_ctrl), 8'h00, "R5 locked write ignored");

      // R3 wrong placement last byte
      key(16'h002E, 8'hAA);
      check(8'(cfg_active), 8'h00, "R3 0x2E rejects 0xAA");

      // R4 repeated first byte, R2 stray data write mid-key
      wr(16'h002E, 8'h87);
      wr(16'h002E, 8'h87);
      wr(16'h002E, 8'h01);
      wr(16'h002F, 8'h11);
      wr(16'h002E, 8'h55);
      check(8'(cfg_active), 8'h00, "R2 not open after three bytes");
      wr(16'h002E, 8'h55);
      check(8'(cfg_active), 8'h01, "R4 R2 open after restart key");

      // R6 index register
      wr(16'h002E, 8'h20);
      rd(16'h002E, 8'h20, "R6 index readback");
      // R7 identity
      rd(16'h002F, 8'h5A, "R7 id high");
      wr(16'h002F, 8'hFF);
      rd(16'h002F, 8'h5A, "R7 id high write ignored");
      wr(16'h002E, 8'h21);
      rd(16'h002F, 8'h3C, "R7 id low");
      wr(16'h002E, 8'h22);
      rd(16'h002F, 8'h07, "R7 revision");

      // R10 global control
      wr(16'h002E, 8'h24);
      wr(16'h002F, 8'hFF);
      rd(16'h002F, 8'h3F, "R10 ctrl reserved bits zero");
      check(8'(cfg_ctrl), 8'h3F, "R10 ctrl output");
      wr(16'h002F, 8'h15);
      check(8'(cfg_ctrl), 8'h15, "R10 ctrl output update");

      // R9 banked registers
      wr(16'h002E, 8'h07); wr(16'h002F, 8'h02);
      rd(16'h002F, 8'h02, "R9 ldn readback");
      check(cfg_ldn, 8'h02, "R9 ldn output");
      wr(16'h002E, 8'h31); wr(16'h002F, 8'hA1);
      wr(16'h002E, 8'h07); wr(16'h002F, 8'h05);
      wr(16'h002E, 8'h31); wr(16'h002F, 8'hB2);
      rd(16'h002F, 8'hB2, "R9 bank of device 5");
      wr(16'h002E, 8'h07); wr(16'h002F, 8'h02);
      wr(16'h002E, 8'h31);
      rd(16'h002F, 8'hA1, "R9 bank of device 2 kept");
      wr(16'h002E, 8'h24);
      rd(16'h002F, 8'h15, "R10 ctrl not banked");
      wr(16'h002E, 8'h07); wr(16'h002F, 8'h09);
      wr(16'h002E, 8'h31); wr(16'h002F, 8'hCC);
      rd(16'h002F, 8'h00, "R9 out-of-range device reads zero");
      wr(16'h002E, 8'h07); wr(16'h002F, 8'h02);

      // R8 exit
      wr(16'h002E, 8'h02);
      wr(16'h002F, 8'h01);
      check(8'(cfg_active), 8'h01, "R8 wrong exit value");
      wr(16'h002F, 8'h02);
      check(8'(cfg_active), 8'h00, "R8 exit");
      rd(16'h002F, 8'hFF, "R5 read after exit");
      wr(16'h002E, 8'h24);
      wr(16'h002F, 8'h00);
      check(8'(cfg_ctrl), 8'h15, "R5 locked ctrl write ignored");

      // R3 second placement
      base_sel = 1'b1;
      key(16'h004E, 8'h55);
      check(8'(cfg_active), 8'h00, "R3 0x4E rejects 0x55");
      key(16'h004E, 8'hAA);
      check(8'(cfg_active), 8'h01, "R3 0x4E opens with 0xAA");
      wr(16'h004E, 8'h22);
      rd(16'h004F, 8'h07, "R3 revision at 0x4F");
      rd(16'h002E, 8'h07, "R11 unselected port holds rdata");
      wr(16'h004E, 8'h02);
      wr(16'h004F, 8'h02);
      check(8'(cfg_active), 8'h00, "R8 exit at 0x4E");

      repeat (3) @(negedge clk);
      check(8'(exp_q.size()), 8'h00, "R11 all reads answered");
      finished = 1'b1;
      finish_run();
   end

endmodule